// File: doc/BRIEF.md
# Addressable Cascadable Shift Register

This block is a chain of four 32-bit serial shift cells that together model a bank of lookup tables used as shift storage. On every clock edge with the shift enable high, each cell moves its contents up one place. Cell 0 takes a new bit from the serial input. Every later cell takes the bit that falls out of the end of the cell before it, so the chain can be up to 128 bits long. Each cell also shows its oldest bit on its own cascade output.

A 7-bit tap address reads one bit from the chain. The upper 2 bits pick a cell and the lower 5 bits pick a place inside that cell. A build-time parameter sets the tap mode. In dynamic mode the tap is a pure multiplexer, so it follows the address at once. In static mode the tap place is fixed by a parameter, the address input is ignored, and the chosen bit passes through an output flip-flop. The stored bits have no reset. The reset input only clears that output flip-flop.

Top module: `tap_shift_chain`

## Requirements
- R1: On each rising clock edge with `shift_en` high, every cell shifts by one place. The new bit 0 of cell 0 is `serial_in`.
- R2: `cell_casc[k]` always shows bit 31 of cell k, which is the bit shifted in 32 enabled edges earlier.
- R3: Cell k (k ≥ 1) takes its new bit from `cell_casc[k-1]`. A bit driven on `serial_in` therefore appears on `cell_casc[3]` after 128 enabled edges.
- R4: A global address splits as `tap_addr[6:5]` for the cell and `tap_addr[4:0]` for the place in that cell. Place 0 is the most recently shifted-in bit, so global place p holds the bit shifted in p+1 enabled edges ago.
- R5: In dynamic mode, `tap_out` shows the addressed bit combinationally. It follows a change of `tap_addr` with no clock edge.
- R6: In static mode, `tap_addr` has no effect. On each enabled edge, `tap_out` loads the bit that sat at global place FIXED_TAP just before that edge.
- R7: With `shift_en` low, the stored bits, the cascade outputs and the static-mode output all hold.
- R8: Driving `rst_n` low clears the static-mode output flip-flop to 0 at once. The release is synchronised over two edges. Reset leaves the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the static output flip-flop only |
| shift_en | input | 1 | Clock enable for shifting and for the output flip-flop |
| serial_in | input | 1 | Serial data into cell 0 |
| tap_addr | input | 7 | Global tap address (cell, place); ignored in static mode |
| tap_out | output | 1 | Selected bit; combinational or registered, depending on the mode |
| cell_casc | output | 4 | Oldest bit of each cell |

## Verification
The results fall due at different times:
- A dynamic tap is due one time unit after its address changes, still before the next rising edge. The bench checks it there, which shows that no clock is involved.
- The stored contents, the cascade outputs and the static output all change on the rising edge that shifts. They are compared at the following falling edge against a 128-entry queue that is pushed only when the enable was high at that edge.
- The static output is expected to hold the queue entry at the fixed place as it stood before the push.
- After a reset release, the bench spends two idle cycles so the synchroniser is clear before the static output can load again.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic {
    TSC_DYNAMIC = 1'b0,
    TSC_STATIC  = 1'b1
  } tsc_mode_e;
endpackage

// File: rtl/tsc_cell.sv
module tsc_cell #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din,
  input  logic [LW-1:0] addr,
  output logic          tap,
  output logic          casc
);
  logic [DEPTH-1:0] bits_q;
  logic [DEPTH-1:0] bits_d;

  // next state: shift one place when enabled, else hold
  always_comb begin
    bits_d = bits_q;
    if (en) begin
      bits_d = {bits_q[DEPTH-2:0], din};
    end
  end

  // storage carries no reset by design
  always_ff @(posedge clk) begin
    bits_q <= bits_d;
  end

  assign tap  = bits_q[addr];
  assign casc = bits_q[DEPTH-1];

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> bits_q[0] == $past(din));

  a_r2_oldest_out: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> casc == $past(bits_q[DEPTH-2]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(casc) && $stable(tap) || $changed(addr));
endmodule

// File: rtl/tsc_tap_sel.sv
module tsc_tap_sel #(
  parameter int CELLS = 4,
  parameter int CW    = $clog2(CELLS)
) (
  input  logic [CELLS-1:0] taps,
  input  logic [CW-1:0]    sel,
  output logic             y
);
  always_comb begin
    y = taps[sel];
  end
endmodule

// File: rtl/tap_shift_chain.sv
module tap_shift_chain
  import tsc_pkg::*;
#(
  parameter int        CELLS     = 4,
  parameter int        DEPTH     = 32,
  parameter tsc_mode_e MODE      = TSC_DYNAMIC,
  parameter int        AW        = $clog2(CELLS) + $clog2(DEPTH),
  parameter int        FIXED_TAP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             serial_in,
  input  logic [AW-1:0]    tap_addr,
  output logic             tap_out,
  output logic [CELLS-1:0] cell_casc
);
  localparam int LW = $clog2(DEPTH);
  localparam int CW = AW - LW;

  logic [CELLS-1:0] cell_din;
  logic [CELLS-1:0] cell_tap;
  logic [AW-1:0]    sel_addr;
  logic             sel_bit;

  // in static mode the tap place is a build-time constant
  always_comb begin
    sel_addr = (MODE == TSC_STATIC) ? AW'(FIXED_TAP) : tap_addr;
  end

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    if (k == 0) begin : g_head
      assign cell_din[k] = serial_in;
    end else begin : g_link
      assign cell_din[k] = cell_casc[k-1];
    end

    tsc_cell #(.DEPTH(DEPTH), .LW(LW)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (shift_en),
      .din  (cell_din[k]),
      .addr (sel_addr[LW-1:0]),
      .tap  (cell_tap[k]),
      .casc (cell_casc[k])
    );
  end

  tsc_tap_sel #(.CELLS(CELLS), .CW(CW)) u_sel (
    .taps(cell_tap),
    .sel (sel_addr[AW-1:LW]),
    .y   (sel_bit)
  );

  if (MODE == TSC_STATIC) begin : g_static
    logic [1:0] rs_q;
    logic       out_q;
    logic       out_d;

    // asynchronous assertion, synchronous release
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs_q <= 2'b00;
      else        rs_q <= {rs_q[0], 1'b1};
    end

    always_comb begin
      out_d = out_q;
      if (rs_q[1] && shift_en) begin
        out_d = sel_bit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
    end

    assign tap_out = out_q;

    a_r6_static_load: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && rs_q[1]) |=> tap_out == $past(sel_bit));

    a_r7_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(tap_out));
  end else begin : g_dynamic
    assign tap_out = sel_bit;
  end
endmodule

// File: tb/test_tap_shift_chain.sv
module test_tap_shift_chain;
  import tsc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 128;
  localparam int FIX        = 77;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b0;
  logic       din = 1'b0;
  logic [6:0] addr = 7'd0;
  logic       tap_d, tap_s;
  logic [3:0] casc_d, casc_s;

  int checks = 0;
  int errors = 0;
  bit mq[$];
  bit st_exp = 1'b0;
  bit st_known = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_shift_chain i_tap_shift_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(en), .serial_in(din),
    .tap_addr(addr), .tap_out(tap_d), .cell_casc(casc_d)
  );

  tap_shift_chain #(.MODE(TSC_STATIC), .FIXED_TAP(FIX)) i_tap_shift_chain_static (
    .clk(clk), .rst_n(rst_n), .shift_en(en), .serial_in(din),
    .tap_addr(addr), .tap_out(tap_s), .cell_casc(casc_s)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    if (mq.size() == N) begin
      chk("R4", "dynamic tap", tap_d, mq[addr]);
      for (int k = 0; k < 4; k++) begin
        chk("R2 R3", "cascade dyn", casc_d[k], mq[32*k+31]);
        chk("R2 R3", "cascade static", casc_s[k], mq[32*k+31]);
      end
    end
    if (st_known) chk("R6 R7", "static tap", tap_s, st_exp);
  endtask

  // drive after a falling edge, check the tap before the rising edge,
  // update the model at the rising edge, compare at the next falling edge
  task automatic cyc(bit e, bit d, logic [6:0] a);
    en = e; din = d; addr = a;
    #1;
    if (mq.size() == N) chk("R5", "tap follows address", tap_d, mq[a]);
    @(posedge clk);
    if (e) begin
      if (mq.size() > FIX) begin
        st_exp = mq[FIX];
        st_known = 1'b1;
      end else begin
        st_known = 1'b0;
      end
      mq.push_front(d);
      if (mq.size() > N) void'(mq.pop_back());
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic reset_pulse();
    en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8", "static out cleared", tap_s, 1'b0);
    st_exp = 1'b0;
    st_known = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare_all();   // R8: contents untouched by reset
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 7'd0);
    cyc(1'b0, 1'b0, 7'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reset_pulse();
    chk("R8", "static out after reset", tap_s, 1'b0);
    // fill the whole chain (R1, R3)
    for (int i = 0; i < N; i++) cyc(1'b1, 1'($urandom), 7'($urandom));
    // random shifting with gaps in the enable (R1, R4, R6, R7)
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 4) != 0, 1'($urandom), 7'($urandom));
    // address sweep with no shifting (R4, R5, R6 address ignored)
    for (int a = 0; a < N; a++) cyc(1'b0, 1'($urandom), 7'(a));
    // reset in mid-run keeps contents (R8)
    reset_pulse();
    // long hold with the serial input toggling (R7)
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'(i), 7'($urandom));
    // directed marker through the full chain (R3)
    cyc(1'b1, 1'b1, 7'd127);
    for (int i = 0; i < N - 1; i++) cyc(1'b1, 1'b0, 7'd127);
    chk("R3", "marker at chain end", casc_d[3], 1'b1);
    for (int i = 0; i < 300; i++)
      cyc(($urandom % 3) != 0, 1'($urandom), 7'($urandom));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule